// File: doc/BRIEF.md
# Tone-Burst Serial Command Modulator

This block carries command bytes from a host to a satellite dish controller by switching a square-wave tone (nominally 22 kHz) on and off. The host pushes bytes into a small first-in first-out store through a one-cycle write strobe and watches the empty and full flags. Whenever a byte is waiting, the block pulls it, appends an odd parity bit and sends the nine bits one after another. Each bit is a fixed window of tone periods. The share of that window during which the tone sounds tells a one from a zero.

Timing comes from an input enable pulse, `tone_tick`, that arrives at twice the tone frequency, so one tone period is two ticks. While gating is on, the output flips on every tick. While gating is off, the output rests low. A mode input picks one of two zero codings: a short burst that leaves a gap, or a tone that sounds for the whole bit window. Frames follow each other with no gap for as long as the store holds bytes.

Top module: `tone_cmd_tx`

## Requirements
- R1: After reset, and at any time no frame is in progress, `fifo_empty`=1, `fifo_full`=0, `busy`=0 and `tone_out`=0, and tone ticks have no effect on `tone_out`.
- R2: The store holds 8 bytes. `fifo_full` is 1 exactly when 8 bytes are waiting, and a write made while `fifo_full`=1 is dropped, so that byte is never transmitted.
- R3: A byte written while the block is idle is taken on the next clock edge, and `busy` goes to 1 after that edge.
- R4: A frame is nine bits: the data byte, most significant bit first, then a parity bit chosen so that the nine bits hold an odd number of ones.
- R5: Every bit lasts exactly 66 tone ticks (33 tone periods), counted from the first tick after the frame starts.
- R6: A one bit gates the tone on for the first 22 ticks (11 periods) and off for the remaining 44.
- R7: A zero bit gates the tone on for the first 44 ticks and off for the last 22 when `zero_short`=1, and on for all 66 ticks when `zero_short`=0.
- R8: `tone_out` changes only on a clock edge that carries a tone tick. While gated on, it flips on each tick, starting from 0, so after the k-th gated tick of a bit (k counted from 1) it equals k mod 2. While gated off it is 0.
- R9: When a frame's last tick comes and another byte is waiting, the next frame starts on the same edge with no idle tick, and `busy` stays 1. `busy` falls on the edge of the last tick of the last frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to queue |
| zero_short | input | 1 | Zero coding: 1 = 2/3 burst, 0 = full-window tone |
| tone_tick | input | 1 | Enable pulse at twice the tone frequency |
| fifo_empty | output | 1 | No byte waiting |
| fifo_full | output | 1 | Eight bytes waiting |
| busy | output | 1 | A frame is being sent |
| tone_out | output | 1 | Gated tone output |

## Verification
The bench builds the block with its default parameters: an 8-byte store, 33-period bits and the 11/22 on-lengths. These values keep a frame short enough that about seventy frames fit in the run. Every tick of every frame is predicted from the parity and on-length arithmetic, for both zero codings and for tick spacings of one and three clocks. The expected values cover bytes that are all zeros, all ones, single-bit, alternating and swept. Bursts of writes fill the store to full and try to push more, so the full flag, the dropped writes and the back-to-back frames all show up at the ports.

// File: rtl/tone_cmd_pkg.sv
package tone_cmd_pkg;

  // Odd parity: the returned bit makes the total count of ones odd.
  function automatic logic odd_parity(input logic [7:0] d);
    return ~(^d);
  endfunction

  // Number of tick slots (half periods) with the tone on for one bit.
  function automatic int unsigned gated_halves(
    input logic        bit_val,
    input logic        short_zero,
    input int unsigned full_halves,
    input int unsigned one_halves,
    input int unsigned short_halves
  );
    if (bit_val)        return one_halves;
    else if (short_zero) return short_halves;
    else                return full_halves;
  endfunction

endpackage

// File: rtl/tcm_fifo.sv
module tcm_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             wr_accept
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_rd;

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign wr_accept = wr_en && !full;
  assign do_rd     = rd_en && !empty;
  assign rd_data   = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_accept) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_accept) wptr <= bump(wptr);
      if (do_rd)     rptr <= bump(rptr);
      if (wr_accept && !do_rd)      count <= count + 1'b1;
      else if (do_rd && !wr_accept) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tcm_framer.sv
module tcm_framer
  import tone_cmd_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned BIT_HALVES   = 66,
  parameter int unsigned ONE_HALVES   = 22,
  parameter int unsigned SHORT_HALVES = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              byte_avail,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              short_zero,
  output logic              pop,
  output logic              active,
  output logic              gate,
  output logic              frame_end,
  output logic [DATA_W:0]   frame_bits
);
  localparam int unsigned FRAME_BITS = DATA_W + 1;
  localparam int unsigned BW = $clog2(FRAME_BITS);
  localparam int unsigned HW = $clog2(BIT_HALVES);

  logic [BW-1:0] bit_idx;
  logic [HW-1:0] half_cnt;
  logic          last_half, last_bit, cur_bit;

  assign cur_bit   = frame_bits[DATA_W];
  assign last_half = (half_cnt == HW'(BIT_HALVES - 1));
  assign last_bit  = (bit_idx == BW'(FRAME_BITS - 1));
  assign frame_end = active && tick && last_half && last_bit;
  assign pop       = byte_avail && (!active || frame_end);

  always_comb begin
    int unsigned on_len;
    on_len = gated_halves(cur_bit, short_zero, BIT_HALVES, ONE_HALVES, SHORT_HALVES);
    gate   = active && (32'(half_cnt) < on_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      bit_idx    <= '0;
      half_cnt   <= '0;
      frame_bits <= '0;
    end else if (pop) begin
      active     <= 1'b1;
      bit_idx    <= '0;
      half_cnt   <= '0;
      frame_bits <= {byte_in, odd_parity(byte_in)};
    end else if (frame_end) begin
      active   <= 1'b0;
      bit_idx  <= '0;
      half_cnt <= '0;
    end else if (active && tick) begin
      if (last_half) begin
        half_cnt   <= '0;
        bit_idx    <= bit_idx + 1'b1;
        frame_bits <= {frame_bits[DATA_W-1:0], 1'b0};
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcm_tone_gate.sv
module tcm_tone_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic gate,
  output logic tone
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tone <= 1'b0;
    else if (!gate)        tone <= 1'b0;
    else if (tick)         tone <= ~tone;
  end
endmodule

// File: rtl/tone_cmd_tx.sv
module tone_cmd_tx #(
  parameter int unsigned FIFO_DEPTH       = 8,
  parameter int unsigned BIT_PERIODS      = 33,
  parameter int unsigned ONE_ON_PERIODS   = 11,
  parameter int unsigned SHORT_ON_PERIODS = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       zero_short,
  input  logic       tone_tick,
  output logic       fifo_empty,
  output logic       fifo_full,
  output logic       busy,
  output logic       tone_out
);
  localparam int unsigned DATA_W       = 8;
  localparam int unsigned BIT_HALVES   = 2 * BIT_PERIODS;
  localparam int unsigned ONE_HALVES   = 2 * ONE_ON_PERIODS;
  localparam int unsigned SHORT_HALVES = 2 * SHORT_ON_PERIODS;

  logic [DATA_W-1:0] head_byte;
  logic              pop_evt, gate_on, frame_end_evt, wr_ok;
  logic [DATA_W:0]   frame_bits;

  tcm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(pop_evt), .rd_data(head_byte),
    .empty(fifo_empty), .full(fifo_full), .wr_accept(wr_ok)
  );

  tcm_framer #(
    .DATA_W(DATA_W), .BIT_HALVES(BIT_HALVES),
    .ONE_HALVES(ONE_HALVES), .SHORT_HALVES(SHORT_HALVES)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tone_tick),
    .byte_avail(!fifo_empty), .byte_in(head_byte),
    .short_zero(zero_short),
    .pop(pop_evt), .active(busy), .gate(gate_on),
    .frame_end(frame_end_evt), .frame_bits(frame_bits)
  );

  tcm_tone_gate u_gate (
    .clk(clk), .rst_n(rst_n), .tick(tone_tick),
    .gate(gate_on), .tone(tone_out)
  );
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       tone_tick,
  input logic       fifo_empty,
  input logic       fifo_full,
  input logic       busy,
  input logic       tone_out,
  input logic       pop_evt,
  input logic       wr_ok,
  input logic [8:0] frame_bits
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tone_out);

  // R2
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));

  // R2
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && !pop_evt) |=> fifo_full);

  // R2
  no_accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !wr_ok);

  // R3
  start_prompt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !fifo_empty) |=> busy);

  // R4
  parity_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> ($countones(frame_bits) % 2 == 1));

  // R8
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_tick |=> $stable(tone_out));

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tone_tick) |=> busy);
endmodule

bind tone_cmd_tx tcm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tone_tick(tone_tick),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .busy(busy),
  .tone_out(tone_out), .pop_evt(pop_evt), .wr_ok(wr_ok),
  .frame_bits(frame_bits)
);

// File: tb/tone_cmd_tx_test.sv
module tone_cmd_tx_test;
  localparam int CLK_PERIOD  = 10;
  localparam int DEPTH       = 8;
  localparam int BIT_TICKS   = 66;
  localparam int FRAME_TICKS = 9 * BIT_TICKS;
  localparam int MAX_CYCLES  = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, zero_short = 1'b1, tone_tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic fifo_empty, fifo_full, busy, tone_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_cmd_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .zero_short(zero_short), .tone_tick(tone_tick),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .busy(busy), .tone_out(tone_out)
  );

  int n_chk = 0, n_bad = 0, cycles = 0, tick_gap = 1, tick_ctr = 0;
  logic want_wr = 1'b0;
  logic [7:0] want_data = '0;
  logic p_wr = 1'b0, p_tick = 1'b0;
  logic [7:0] p_data = '0;
  logic [7:0] q [128];
  int q_head = 0, q_tail = 0, m_count = 0, h = 0;
  logic m_active = 1'b0, exp_tone = 1'b0;
  logic [8:0] m_frame = '0;
  logic finished = 1'b0;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [8:0] build_frame(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(b[i]);
    return {b, (ones % 2 == 0) ? 1'b1 : 1'b0};
  endfunction

  task automatic start_frame();
    m_frame = build_frame(q[q_head]);
    q_head  = (q_head + 1) % 128;
    m_active = 1'b1;
    h = 0;
  endtask

  // One clock: model what the last edge did, compare, then drive the next inputs.
  task automatic cycle();
    int old_count, pos, bidx, on_len;
    logic acc, popped, bv;
    @(negedge clk);
    cycles++;
    if (cycles > MAX_CYCLES) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, MAX_CYCLES);
      finish_run();
    end
    old_count = m_count;
    acc = p_wr && (old_count < DEPTH);
    popped = 1'b0;
    if (m_active && p_tick) begin
      pos  = h % BIT_TICKS;
      bidx = h / BIT_TICKS;
      bv   = m_frame[8 - bidx];                        // R4 MSB first, parity last
      on_len = bv ? 22 : (zero_short ? 44 : 66);       // R6 R7
      exp_tone = (pos < on_len) ? ((pos + 1) % 2 == 1) : 1'b0;  // R8
      h++;
      if (h == FRAME_TICKS) begin                      // R5 R9
        if (old_count > 0) begin start_frame(); popped = 1'b1; end
        else m_active = 1'b0;
      end
    end else if (!m_active && old_count > 0) begin     // R3
      start_frame(); popped = 1'b1;
    end
    if (acc) begin q[q_tail] = p_data; q_tail = (q_tail + 1) % 128; end
    m_count = old_count + (acc ? 1 : 0) - (popped ? 1 : 0);
    check("R8 tone", tone_out, exp_tone);
    check("R9 busy", busy, m_active);
    check("R2 empty", fifo_empty, m_count == 0);
    check("R2 full", fifo_full, m_count == DEPTH);
    // drive
    tone_tick = (tick_ctr == 0);
    tick_ctr  = (tick_ctr + 1) % tick_gap;
    wr_en = want_wr; wr_data = want_data;
    p_tick = tone_tick; p_wr = want_wr; p_data = want_data;
  endtask

  task automatic push(input logic [7:0] b);
    want_wr = 1'b1; want_data = b;
    cycle();
    want_wr = 1'b0;
  endtask

  task automatic drain();
    while (m_active || m_count > 0) cycle();
    repeat (5) cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 empty", fifo_empty, 1'b1);
    check("R1 full", fifo_full, 1'b0);
    check("R1 busy", busy, 1'b0);
    check("R1 tone", tone_out, 1'b0);
    rst_n = 1'b1;
    // R1 ticks while idle leave the output low
    repeat (20) cycle();

    // R3 R4 single frame, short zero coding, tick every clock
    zero_short = 1'b1; tick_gap = 1;
    push(8'hA5);
    drain();

    // R2 R9 burst beyond capacity: the later writes hit a full store
    begin
      logic [7:0] pat [12] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h55, 8'hAA,
                               8'h0F, 8'hF0, 8'h3C, 8'hC3, 8'h7E, 8'h81};
      for (int i = 0; i < 12; i++) push(pat[i]);
      drain();
      // R7 full-window zero coding, ticks every third clock
      zero_short = 1'b0; tick_gap = 3; tick_ctr = 0;
      for (int i = 0; i < 12; i++) push(pat[i]);
      drain();
    end

    // R4 R6 R7 swept bytes, writes held off while full, both codings
    tick_gap = 1; tick_ctr = 0;
    for (int s = 0; s < 2; s++) begin
      zero_short = (s == 0);
      for (int i = 0; i < 24; i++) begin
        while (m_count >= DEPTH) cycle();
        push(8'((i * 37 + s * 11 + 3) & 8'hFF));
        repeat (i % 5) cycle();
      end
      drain();
    end

    // R1 idle again after all traffic
    check("R1 idle busy", busy, 1'b0);
    check("R1 idle empty", fifo_empty, 1'b1);
    finish_run();
  end
endmodule